// File: doc/BRIEF.md
# Rotating Drum Word Transfer Controller

This block is the control side of a rotating drum store attached to a data channel. A free-running angle counter models the drum surface passing under the heads. It advances one position per word slot and wraps once per revolution. The slot that begins at position zero is longer, which models the index gap. Slot lengths are parameters given in clock cycles, so one design serves both real word timing and short test timing.

A command port accepts read or write selections for one drum unit. An accepted command selects the channel, clears the drum address and restarts the slot timer with a start-up delay. From then on, one 36-bit word moves each time the angle counter equals the drum address, as long as the channel is active. In the read direction the word goes from the backing array to the channel. In the write direction it goes from the channel into the array. After each word the address steps on. An end-of-record or timing-error report ends the selection but keeps the command. A channel disconnect clears everything.

Top module: `drum_xfer_ctrl`

## Requirements
- R1: The angle output `rot_pos` advances by exactly one every `SLOT_CYC` clock cycles and wraps from 2^`ADDR_W`-1 to 0. It changes at no other time.
- R2: When `rot_pos` has just become 0, the following slot lasts `INDEX_CYC` cycles instead of `SLOT_CYC`.
- R3: A command (`cmd_valid` high for one cycle) is answered in the next cycle with `resp_valid` high and a `resp_code`. Code 00 means accepted. Code 01 means I/O error. It is returned for an operation other than 01 (read) or 10 (write), and for any command while `media_ok` is low.
- R4: A command whose `cmd_unit` is not below `UNITS` is answered with code 10 (no device). This check takes priority over the I/O-error cases. A rejected command leaves `chan_sel`, `chan_wr` and `cmd_held` unchanged.
- R5: An accepted command sets `chan_sel` and `cmd_held`, sets `chan_wr` to 1 for write and 0 for read, and clears `cur_addr` to 0. It restarts the slot timer, so the next step of `rot_pos` comes `START_CYC` cycles after the accepting clock edge.
- R6: A word is offered only in the slot where `chan_active` is high, `chan_sel` is high, a read or write is pending and `rot_pos` equals `cur_addr`. A read word is held on `rd_valid`/`rd_data` until `rd_ready`. Never are `rd_valid` and `wr_ready` high together.
- R7: The backing array is indexed by the unit number times 2^`ADDR_W` plus `cur_addr`, so each unit's words are kept apart from every other unit's.
- R8: Each completed word handshake increments `cur_addr` modulo 2^`ADDR_W`.
- R9: In the write direction `wr_ready` is offered and `wr_data` is stored on `wr_valid`. `hwmark` holds one more than the highest array index written since reset, which is 0 after reset.
- R10: If `ch_eor` or `ch_terr` is high while a word is offered, no word moves, `cur_addr` holds, `chan_sel` drops, and `cmd_held` stays high.
- R11: If `ch_disco` is high while a command is held, the command is cleared at the next slot step or at once if a word is offered: `cmd_held`, `chan_sel`, `rd_valid` and `wr_ready` all go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Operation: 01 read, 10 write, others illegal |
| cmd_unit | input | UNIT_W | Drum unit number |
| media_ok | input | 1 | Backing medium present |
| resp_valid | output | 1 | Command response strobe |
| resp_code | output | 2 | 00 accepted, 01 I/O error, 10 no device |
| chan_active | input | 1 | Channel is running a transfer |
| chan_sel | output | 1 | Controller has the channel selected |
| chan_wr | output | 1 | Direction of the held command, 1 = write |
| cmd_held | output | 1 | A command is held |
| rd_valid | output | 1 | Read word offered to the channel |
| rd_data | output | 36 | Read word |
| rd_ready | input | 1 | Channel takes the read word |
| wr_ready | output | 1 | Write word requested from the channel |
| wr_valid | input | 1 | Channel supplies the write word |
| wr_data | input | 36 | Write word |
| ch_eor | input | 1 | Channel end-of-record |
| ch_terr | input | 1 | Channel timing error |
| ch_disco | input | 1 | Channel disconnect |
| rot_pos | output | ADDR_W | Current angle position |
| cur_addr | output | ADDR_W | Drum address of the next word |
| hwmark | output | ADDR_W+clog2(UNITS)+1 | One past the highest index written |

## Verification
A wrong angle counter or slot timer shows on `rot_pos` within one slot as a wrong step or a wrong slot length. The bench times every slot of a full revolution, as well as the start-up delay after a command. A wrong address or index shows at the next handshake: `rot_pos` differs from `cur_addr` when a word is offered, `cur_addr` fails to step, or a word read back differs from the word written to that unit. A wrong abort state shows within a cycle as `chan_sel` or `cmd_held` staying high, or a stray word being stored, which is caught through `hwmark`.

// File: rtl/drum_pkg.sv
// Shared constants and encodings for the drum transfer controller.
// Assumes: words are 36 bits wide; operation and response codes are 2 bits.
package drum_pkg;
    localparam int WORD_W = 36;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSVD  = 2'b11
    } drum_op_e;

    typedef enum logic [1:0] {
        RSP_OK    = 2'b00,
        RSP_IOERR = 2'b01,
        RSP_NODEV = 2'b10
    } drum_rsp_e;
endpackage

// File: rtl/drum_rotor.sv
// Angle counter and slot timer. Steps pos once per slot and pulses slot_evt
// in the cycle where the new position is visible. The slot after pos becomes
// zero lasts INDEX_CYC; restart reloads the timer with START_CYC.
// Assumes: every cycle count is at least 2.
module drum_rotor #(
    parameter int ADDR_W    = 11,
    parameter int SLOT_CYC  = 24000,
    parameter int INDEX_CYC = 30000,
    parameter int START_CYC = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic [ADDR_W-1:0] pos,
    output logic              slot_evt
);
    localparam int MAX_A = (SLOT_CYC > INDEX_CYC) ? SLOT_CYC : INDEX_CYC;
    localparam int MAX_C = (MAX_A > START_CYC) ? MAX_A : START_CYC;
    localparam int TW    = $clog2(MAX_C + 1);

    logic [TW-1:0]     timer;
    logic [ADDR_W-1:0] pos_nxt;

    assign pos_nxt = pos + 1'b1;

    // Count down the current slot and step the angle when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= '0;
            timer    <= TW'(INDEX_CYC);
            slot_evt <= 1'b0;
        end else if (restart) begin
            timer    <= TW'(START_CYC);
            slot_evt <= 1'b0;
        end else if (timer == TW'(1)) begin
            pos      <= pos_nxt;
            timer    <= (pos_nxt == '0) ? TW'(INDEX_CYC) : TW'(SLOT_CYC);
            slot_evt <= 1'b1;
        end else begin
            timer    <= timer - 1'b1;
            slot_evt <= 1'b0;
        end
    end

    // R1: each step moves the angle by exactly one position.
    p_pos_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_evt |-> (pos == $past(pos) + 1'b1));

    // R1: the angle never moves outside a slot step.
    p_pos_still_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != $past(pos)) |-> slot_evt);
endmodule

// File: rtl/drum_cmd_dec.sv
// Command decoder. Classifies a command as accepted, I/O error or no device.
// Assumes: unit range is checked before medium and operation code.
module drum_cmd_dec
    import drum_pkg::*;
#(
    parameter int UNIT_W = 2,
    parameter int UNITS  = 1
) (
    input  logic [1:0]        op,
    input  logic [UNIT_W-1:0] unit,
    input  logic              media_ok,
    output logic              accept,
    output logic              is_write,
    output logic [1:0]        code
);
    localparam logic [UNIT_W:0] UNIT_LIM = (UNIT_W + 1)'(UNITS);

    // Rank the reject reasons and pick the response code.
    always_comb begin
        accept   = 1'b0;
        is_write = 1'b0;
        code     = RSP_IOERR;
        if ({1'b0, unit} >= UNIT_LIM) begin
            code = RSP_NODEV;
        end else if (media_ok) begin
            case (drum_op_e'(op))
                OP_READ: begin
                    accept = 1'b1;
                    code   = RSP_OK;
                end
                OP_WRITE: begin
                    accept   = 1'b1;
                    is_write = 1'b1;
                    code     = RSP_OK;
                end
                default: code = RSP_IOERR;
            endcase
        end
    end
endmodule

// File: rtl/drum_store.sv
// Backing word array with registered read and a high-water mark.
// Assumes: read and write share one index; a read in the cycle of a write
// returns the old word.
module drum_store #(
    parameter int IDX_W  = 11,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [IDX_W:0]    hwmark
);
    localparam int DEPTH = 2 ** IDX_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [IDX_W:0]    idx_next;

    assign idx_next = {1'b0, idx} + 1'b1;

    // Write the array on request and read the addressed word every cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
        rdata <= mem[idx];
    end

    // Keep one past the highest index written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hwmark <= '0;
        end else if (we && (idx_next > hwmark)) begin
            hwmark <= idx_next;
        end
    end

    // R9: the high-water mark never falls.
    p_hw_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hwmark >= $past(hwmark));

    // R9: after a write the mark covers the written index.
    p_hw_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (hwmark > {1'b0, $past(idx)}));
endmodule

// File: rtl/drum_xfer_ctrl.sv
// Drum word transfer controller. Holds the command state, gates each word on
// angle match, runs the channel handshake and handles end/abort reports.
// Assumes: the channel holds a status input until it is acted on; slot
// lengths are at least 2 cycles.
module drum_xfer_ctrl
    import drum_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int UNIT_W    = 2,
    parameter int UNITS     = 1,
    parameter int SLOT_CYC  = 24000,
    parameter int INDEX_CYC = 30000,
    parameter int START_CYC = 25000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_valid,
    input  logic [1:0]                        cmd_op,
    input  logic [UNIT_W-1:0]                 cmd_unit,
    input  logic                              media_ok,
    output logic                              resp_valid,
    output logic [1:0]                        resp_code,
    input  logic                              chan_active,
    output logic                              chan_sel,
    output logic                              chan_wr,
    output logic                              cmd_held,
    output logic                              rd_valid,
    output logic [WORD_W-1:0]                 rd_data,
    input  logic                              rd_ready,
    output logic                              wr_ready,
    input  logic                              wr_valid,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic                              ch_eor,
    input  logic                              ch_terr,
    input  logic                              ch_disco,
    output logic [ADDR_W-1:0]                 rot_pos,
    output logic [ADDR_W-1:0]                 cur_addr,
    output logic [ADDR_W+$clog2(UNITS):0]     hwmark
);
    localparam int IDX_W = ADDR_W + $clog2(UNITS);

    logic              slot_evt;
    logic              dec_accept;
    logic              dec_write;
    logic [1:0]        dec_code;
    logic              accept;
    logic              rd_pend;
    logic              wr_pend;
    logic              held;
    logic              sel;
    logic              busy;
    logic [UNIT_W-1:0] unit_q;
    logic [ADDR_W-1:0] daddr;
    logic [IDX_W-1:0]  idx;
    logic              abort_rep;
    logic              disco_hit;
    logic              word_done;
    logic              match;
    logic              store_we;

    drum_rotor #(
        .ADDR_W    (ADDR_W),
        .SLOT_CYC  (SLOT_CYC),
        .INDEX_CYC (INDEX_CYC),
        .START_CYC (START_CYC)
    ) u_rotor (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .pos      (rot_pos),
        .slot_evt (slot_evt)
    );

    drum_cmd_dec #(
        .UNIT_W (UNIT_W),
        .UNITS  (UNITS)
    ) u_dec (
        .op       (cmd_op),
        .unit     (cmd_unit),
        .media_ok (media_ok),
        .accept   (dec_accept),
        .is_write (dec_write),
        .code     (dec_code)
    );

    // Combine request and status inputs into the events the state machine uses.
    always_comb begin
        accept    = cmd_valid && dec_accept;
        disco_hit = held && ch_disco && (slot_evt || busy);
        abort_rep = busy && (ch_eor || ch_terr);
        word_done = busy && ((rd_pend && rd_ready) || (wr_pend && wr_valid));
        match     = slot_evt && chan_active && sel && (rd_pend || wr_pend)
                    && (rot_pos == daddr);
        store_we  = wr_ready && wr_valid && !ch_eor && !ch_terr && !ch_disco
                    && !accept;
        idx       = IDX_W'({unit_q, daddr});
    end

    // Register the command response one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RSP_OK;
        end else begin
            resp_valid <= cmd_valid;
            resp_code  <= dec_code;
        end
    end

    // Command, selection and transfer state, in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
            held    <= 1'b0;
            sel     <= 1'b0;
            busy    <= 1'b0;
            unit_q  <= '0;
            daddr   <= '0;
        end else if (accept) begin
            rd_pend <= !dec_write;
            wr_pend <= dec_write;
            held    <= 1'b1;
            sel     <= 1'b1;
            busy    <= 1'b0;
            unit_q  <= cmd_unit;
            daddr   <= '0;
        end else if (disco_hit) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
            held    <= 1'b0;
            sel     <= 1'b0;
            busy    <= 1'b0;
        end else if (abort_rep) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
            sel     <= 1'b0;
            busy    <= 1'b0;
        end else if (word_done) begin
            daddr <= daddr + 1'b1;
            busy  <= 1'b0;
        end else if (match) begin
            busy <= 1'b1;
        end
    end

    drum_store #(
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (store_we),
        .idx    (idx),
        .wdata  (wr_data),
        .rdata  (rd_data),
        .hwmark (hwmark)
    );

    assign rd_valid = busy && rd_pend;
    assign wr_ready = busy && wr_pend;
    assign chan_sel = sel;
    assign chan_wr  = wr_pend;
    assign cmd_held = held;
    assign cur_addr = daddr;

    // R6: never both directions at once.
    p_dir_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_ready}));

    // R6: a word is offered only at the matching angle.
    p_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid || wr_ready) |-> (rot_pos == cur_addr));

    // R5: an accepted command leaves address zero and nothing offered.
    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == RSP_OK)
            |-> (cur_addr == '0 && cmd_held && chan_sel && !rd_valid && !wr_ready));

    // R8: a completed handshake advances the address by one.
    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !ch_eor && !ch_terr && !ch_disco && !cmd_valid)
            |=> (cur_addr == $past(cur_addr) + 1'b1));

    // R10: end or timing report drops the selection and keeps the command.
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_valid || wr_ready) && (ch_eor || ch_terr) && !ch_disco && !cmd_valid)
            |=> (!chan_sel && cmd_held && $stable(cur_addr)));

    // R11: disconnect while a word is offered clears everything.
    p_disco_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_valid || wr_ready) && ch_disco && !cmd_valid)
            |=> (!cmd_held && !chan_sel && !rd_valid && !wr_ready));
endmodule

// File: tb/sim_drum_xfer_ctrl.sv
// Self-checking bench for the drum transfer controller with short slots.
module sim_drum_xfer_ctrl;
    localparam int AW = 4;
    localparam int UW = 2;
    localparam int NU = 2;
    localparam int SL = 4;
    localparam int IX = 7;
    localparam int ST = 5;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [UW-1:0] cmd_unit = '0;
    logic          media_ok = 1'b1;
    logic          resp_valid;
    logic [1:0]    resp_code;
    logic          chan_active = 1'b0;
    logic          chan_sel, chan_wr, cmd_held;
    logic          rd_valid;
    logic [35:0]   rd_data;
    logic          rd_ready = 1'b0;
    logic          wr_ready;
    logic          wr_valid = 1'b0;
    logic [35:0]   wr_data = '0;
    logic          ch_eor = 1'b0, ch_terr = 1'b0, ch_disco = 1'b0;
    logic [AW-1:0] rot_pos, cur_addr;
    logic [AW+1:0] hwmark;

    int ntests = 0;
    int nfail  = 0;

    always #2 clk = ~clk;

    drum_xfer_ctrl #(
        .ADDR_W(AW), .UNIT_W(UW), .UNITS(NU),
        .SLOT_CYC(SL), .INDEX_CYC(IX), .START_CYC(ST)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_unit(cmd_unit), .media_ok(media_ok), .resp_valid(resp_valid),
        .resp_code(resp_code), .chan_active(chan_active), .chan_sel(chan_sel),
        .chan_wr(chan_wr), .cmd_held(cmd_held), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_ready(rd_ready), .wr_ready(wr_ready),
        .wr_valid(wr_valid), .wr_data(wr_data), .ch_eor(ch_eor),
        .ch_terr(ch_terr), .ch_disco(ch_disco), .rot_pos(rot_pos),
        .cur_addr(cur_addr), .hwmark(hwmark)
    );

    // Command vectors: {media, op[1:0], unit[1:0], expected code[1:0]}.
    localparam logic [6:0] CMD_TAB [8] = '{
        7'b1_01_00_00, 7'b1_11_01_01, 7'b1_10_01_00, 7'b0_01_00_01,
        7'b1_00_00_01, 7'b1_01_10_10, 7'b0_10_11_10, 7'b1_10_00_00
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [UW-1:0] unit,
                            input logic media, output logic rv, output logic [1:0] code);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_unit = unit; media_ok = media;
        @(negedge clk);
        rv = resp_valid; code = resp_code;
        cmd_valid = 1'b0; media_ok = 1'b1;
    endtask

    task automatic wait_wr(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (wr_ready) begin ok = 1'b1; return; end
            @(negedge clk);
        end
    endtask

    task automatic wait_rd(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (rd_valid) begin ok = 1'b1; return; end
            @(negedge clk);
        end
    endtask

    task automatic write_words(input int n, input logic [35:0] base);
        bit ok;
        for (int i = 0; i < n; i++) begin
            wait_wr(ok);
            chk("R9 wr_ready offered", 64'(ok), 64'(1));
            chk("R6 angle at write", 64'(rot_pos), 64'(i % DEPTH));
            wr_valid = 1'b1; wr_data = base + 36'(i);
            @(negedge clk);
            wr_valid = 1'b0;
            chk("R9 wr_ready drops after word", 64'(wr_ready), 64'(0));
            chk("R8 address step on write", 64'(cur_addr), 64'((i + 1) % DEPTH));
        end
    endtask

    task automatic read_words(input int n, input logic [35:0] base);
        bit ok;
        for (int i = 0; i < n; i++) begin
            wait_rd(ok);
            chk("R6 rd_valid offered", 64'(ok), 64'(1));
            chk("R6 angle at read", 64'(rot_pos), 64'(i % DEPTH));
            chk("R7 read word", 64'(rd_data), 64'(base + 36'(i)));
            @(negedge clk);
            chk("R6 read word held", 64'({rd_valid, rd_data}), 64'({1'b1, base + 36'(i)}));
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
            chk("R6 rd_valid drops after take", 64'(rd_valid), 64'(0));
            chk("R8 address step on read", 64'(cur_addr), 64'((i + 1) % DEPTH));
        end
    endtask

    task automatic end_eor(input logic [AW-1:0] exp_addr);
        @(negedge clk);
        ch_eor = 1'b1;
        if (wr_ready) begin wr_valid = 1'b1; wr_data = 36'hBAD_BAD_BAD; end
        @(negedge clk);
        ch_eor = 1'b0; wr_valid = 1'b0;
        chk("R10 select dropped by eor", 64'(chan_sel), 64'(0));
        chk("R10 command kept after eor", 64'(cmd_held), 64'(1));
        chk("R10 address held after eor", 64'(cur_addr), 64'(exp_addr));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        ntests++; nfail++;
        $display("FAIL R1 watchdog act=%0d exp=done", 100000);
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        logic       rv;
        logic [1:0] code;
        bit         ok;
        bit         exp_sel;
        bit         exp_wr;
        bit         seen;
        int         cnt;
        logic [AW-1:0] p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1, R5, R9).
        chk("R1 reset angle", 64'(rot_pos), 64'(0));
        chk("R5 reset select", 64'({chan_sel, cmd_held, rd_valid, wr_ready}), 64'(0));
        chk("R9 reset hwmark", 64'(hwmark), 64'(0));

        // R1, R2: time every slot over one full revolution.
        p = rot_pos;
        while (rot_pos == p) @(negedge clk);
        for (int s = 0; s < DEPTH + 1; s++) begin
            p = rot_pos;
            cnt = 0;
            while (rot_pos == p && cnt < 50) begin @(negedge clk); cnt++; end
            chk(p == 0 ? "R2 index slot length" : "R1 slot length",
                64'(cnt), 64'(p == 0 ? IX : SL));
            chk("R1 angle step and wrap", 64'(rot_pos), 64'(AW'(p + 1'b1)));
        end

        // R3, R4, R5: command table with the channel idle.
        exp_sel = 1'b0; exp_wr = 1'b0;
        for (int v = 0; v < 8; v++) begin
            send_cmd(CMD_TAB[v][5:4], CMD_TAB[v][3:2], CMD_TAB[v][6], rv, code);
            chk("R3 response strobe", 64'(rv), 64'(1));
            chk(CMD_TAB[v][1:0] == 2'b10 ? "R4 no-device code" : "R3 response code",
                64'(code), 64'(CMD_TAB[v][1:0]));
            if (CMD_TAB[v][1:0] == 2'b00) begin
                exp_sel = 1'b1; exp_wr = (CMD_TAB[v][5:4] == 2'b10);
                chk("R5 address cleared", 64'(cur_addr), 64'(0));
            end
            chk("R4 R5 select state", 64'({chan_sel, cmd_held, chan_wr}),
                64'({exp_sel, exp_sel, exp_wr}));
        end

        // R6: no word while the channel is not active.
        seen = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (wr_ready || rd_valid) seen = 1'b1;
        end
        chk("R6 no word without active channel", 64'(seen), 64'(0));

        // R9, R10: write unit 1, end by eor with a stray word.
        chan_active = 1'b1;
        send_cmd(2'b10, 2'd1, 1'b1, rv, code);
        chk("R5 write accepted", 64'(code), 64'(0));
        write_words(3, 36'h1_0000_0000);
        wait_wr(ok);
        end_eor(AW'(3));
        chk("R9 R10 hwmark after unit 1 write", 64'(hwmark), 64'(DEPTH + 3));

        // R7: write unit 0 with other data; mark keeps its maximum.
        send_cmd(2'b10, 2'd0, 1'b1, rv, code);
        write_words(3, 36'h2_0000_0000);
        wait_wr(ok);
        end_eor(AW'(3));
        chk("R9 hwmark keeps maximum", 64'(hwmark), 64'(DEPTH + 3));

        // R7, R10: read unit 1 back, end by timing error.
        send_cmd(2'b01, 2'd1, 1'b1, rv, code);
        chk("R5 read direction", 64'(chan_wr), 64'(0));
        read_words(3, 36'h1_0000_0000);
        wait_rd(ok);
        ch_terr = 1'b1; rd_ready = 1'b1;
        @(negedge clk);
        ch_terr = 1'b0; rd_ready = 1'b0;
        chk("R10 select dropped by timing error", 64'({chan_sel, cmd_held}), 64'({1'b0, 1'b1}));
        chk("R10 address held after timing error", 64'(cur_addr), 64'(3));

        // R7: unit 0 words are apart from unit 1 words.
        send_cmd(2'b01, 2'd0, 1'b1, rv, code);
        read_words(3, 36'h2_0000_0000);
        wait_rd(ok);
        end_eor(AW'(3));

        // R5: start-up delay measured from the accepting edge.
        chan_active = 1'b0;
        send_cmd(2'b01, 2'd0, 1'b1, rv, code);
        p = rot_pos; cnt = 0;
        while (rot_pos == p && cnt < 50) begin @(negedge clk); cnt++; end
        chk("R5 start delay", 64'(cnt), 64'(ST));

        // R11: disconnect at a slot step clears the command.
        ch_disco = 1'b1;
        cnt = 0;
        while (cmd_held && cnt < 20) begin @(negedge clk); cnt++; end
        ch_disco = 1'b0;
        chk("R11 disconnect at slot step", 64'({cmd_held, chan_sel}), 64'(0));

        // R11: disconnect while a word is offered.
        chan_active = 1'b1;
        send_cmd(2'b01, 2'd0, 1'b1, rv, code);
        wait_rd(ok);
        ch_disco = 1'b1;
        @(negedge clk);
        ch_disco = 1'b0;
        chk("R11 disconnect during word", 64'({cmd_held, chan_sel, rd_valid}), 64'(0));

        // R8: address wraps; the seventeenth word overwrites index 0.
        send_cmd(2'b10, 2'd0, 1'b1, rv, code);
        write_words(DEPTH + 1, 36'h3_0000_0000);
        wait_wr(ok);
        end_eor(AW'(1));
        send_cmd(2'b01, 2'd0, 1'b1, rv, code);
        wait_rd(ok);
        chk("R8 wrapped word at index 0", 64'(rd_data), 64'(36'h3_0000_0000 + 36'(DEPTH)));
        end_eor(AW'(0));

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule